// File: doc/BRIEF.md
# Scaled Pixel Serializer

This block turns one fetched video byte into a run of pixel colour codes. It shares a one-hot, eight-position phase register with the memory sequencer: each bit marks one fast clock within a slow access period, and bit 0 is the first of them. A byte arrives on a valid/ready input. The block takes the byte only on the first phase of a period. It splits the byte by the colour depth chosen at that moment into eight, four or two pixels, most significant pixel first, and presents them one after another on a 4-bit output.

The horizontal scale input stretches each pixel over one, two or four fast clocks. Pixel advance is not driven by a separate divider. It is gated by comparing the phase register against a fixed bit mask for each scale. While no pixel is due, the output is blank (zero) and the active flag is low. Palette mapping and sync generation are done by neighbouring blocks.

The input handshake: `byte_ready` is high exactly in the phase-0 clock. A byte transfers on a rising edge where `byte_valid` and `byte_ready` are both high. A source that has a byte must hold it with `byte_valid` high until that edge. At other times the block takes no notice of `byte_valid`. There is no output back-pressure, because the pixel stream is paced by the phase register alone.

Top module: `pix_serializer`

## Requirements
- R1: `phase` is one-hot, with bit 0 marking the first clock of a period. `byte_ready` equals `phase[0]`, and a byte transfers only on a rising edge where `byte_valid` and `byte_ready` are both high.
- R2: In the cycle after a transfer, `pix_active` is 1 and `pix` shows the first (most significant) pixel of the new byte.
- R3: `depth` code 0 gives eight 1-bit pixels, code 1 gives four 2-bit pixels, and codes 2 and 3 give two 4-bit pixels. Pixels leave most significant first and are zero-extended into the low bits of `pix`.
- R4: Outside a load edge, an active pixel advances on a rising edge when the scale allows it. With `scale` code 0 it advances on every edge. With code 1 it advances when `phase & 8'h55` is nonzero. With codes 2 and 3 it advances when `phase & 8'h11` is nonzero. Otherwise `pix` holds.
- R5: An advance taken while the last pixel of the byte is shown makes `pix_active` 0. `pix` is 0 whenever `pix_active` is 0.
- R6: A transfer while pixels are still being shown drops the rest of the old byte and starts the new one, as in R2.
- R7: `depth` is taken at the transfer edge. Changing it while a byte is being shown does not alter that byte's pixels.
- R8: Reset (`rst_n` low, asynchronous) forces `pix` to 0 and `pix_active` to 0 at once.
- R9: `byte_valid` raised in any phase other than phase 0 loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 8 | One-hot phase register, bit 0 is the first clock of a period |
| scale | input | 2 | Horizontal scale code: 0 is x1, 1 is x2, 2 and 3 are x4 |
| depth | input | 2 | Colour depth code: 0 is 1 bpp, 1 is 2 bpp, 2 and 3 are 4 bpp |
| byte_data | input | 8 | Fetched display byte |
| byte_valid | input | 1 | Byte offered |
| byte_ready | output | 1 | Byte can be taken this cycle (phase 0) |
| pix | output | 4 | Current pixel colour code |
| pix_active | output | 1 | A pixel is being shown |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and an eight-position phase register. This is the only shape in which the fixed scale masks and the three depths are defined. With these values a 1-bpp byte at scale x4 lasts four periods, so new bytes arrive while pixels are still being shown. This makes the restart of R6 and the depth changes in the middle of a byte of R7 common under random stimulus. Directed runs pin down the exact hold lengths at each scale. They also cover both spare codes, a valid raised off phase 0, and a reset asserted in the middle of a byte.

// File: rtl/pix_serializer_pkg.sv
package pix_serializer_pkg;

  localparam int unsigned PIX_W = 4;

  typedef enum logic [1:0] {
    DEPTH_BPP1  = 2'd0,
    DEPTH_BPP2  = 2'd1,
    DEPTH_BPP4  = 2'd2,
    DEPTH_BPP4B = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    SCALE_X1  = 2'd0,
    SCALE_X2  = 2'd1,
    SCALE_X4  = 2'd2,
    SCALE_X4B = 2'd3
  } scale_e;

  function automatic logic [2:0] depth_bpp(input logic [1:0] code);
    case (code)
      DEPTH_BPP1: return 3'd1;
      DEPTH_BPP2: return 3'd2;
      default:    return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pix_phase_gate.sv
module pix_phase_gate #(
  parameter int unsigned PHASES = 8
) (
  input  logic [PHASES-1:0] phase,
  input  logic [1:0]        scale,
  output logic              advance
);
  import pix_serializer_pkg::*;

  logic [PHASES-1:0] mask_x2;
  logic [PHASES-1:0] mask_x4;

  for (genvar gi = 0; gi < PHASES; gi++) begin : g_mask
    assign mask_x2[gi] = ((gi % 2) == 0);
    assign mask_x4[gi] = ((gi % 4) == 0);
  end

  always_comb begin
    case (scale)
      SCALE_X1: advance = 1'b1;
      SCALE_X2: advance = |(phase & mask_x2);
      default:  advance = |(phase & mask_x4);
    endcase
  end

endmodule

// File: rtl/pix_shift_unit.sv
module pix_shift_unit #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load,
  input  logic [BYTE_W-1:0]                      byte_in,
  input  logic [1:0]                             depth,
  input  logic                                   advance,
  output logic [pix_serializer_pkg::PIX_W-1:0]   pix,
  output logic                                   active
);
  import pix_serializer_pkg::*;

  localparam int unsigned LEFT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;
  logic [2:0]        bpp_q;
  logic [2:0]        bpp_n;
  logic [LEFT_W-1:0] left_n;

  always_comb begin
    bpp_n = depth_bpp(depth);
    case (bpp_n)
      3'd1:    left_n = LEFT_W'(BYTE_W - 1);
      3'd2:    left_n = LEFT_W'(BYTE_W / 2 - 1);
      default: left_n = LEFT_W'(BYTE_W / 4 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      bpp_q  <= 3'd1;
      active <= 1'b0;
    end else if (load) begin
      sh_q   <= byte_in;
      left_q <= left_n;
      bpp_q  <= bpp_n;
      active <= 1'b1;
    end else if (active && advance) begin
      if (left_q == '0) begin
        sh_q   <= '0;
        active <= 1'b0;
      end else begin
        sh_q   <= sh_q << bpp_q;
        left_q <= left_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (bpp_q)
      3'd1:    pix = {{(PIX_W-1){1'b0}}, sh_q[BYTE_W-1]};
      3'd2:    pix = {{(PIX_W-2){1'b0}}, sh_q[BYTE_W-1 -: 2]};
      default: pix = sh_q[BYTE_W-1 -: PIX_W];
    endcase
  end

  AST_LOAD_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active) else $error("load did not activate");  // R2
  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pix == '0)) else $error("pixel not blank");  // R5
  AST_HOLD_WITHOUT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !advance && !load) |=> (active && $stable(pix))) else $error("pixel moved");  // R4
  AST_RISE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(load)) else $error("active without load");  // R9

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PHASES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] phase,
  input  logic [1:0]        scale,
  input  logic [1:0]        depth,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  output logic [3:0]        pix,
  output logic              pix_active
);

  logic advance;
  logic load;

  assign byte_ready = phase[0];
  assign load       = byte_valid && byte_ready;

  pix_phase_gate #(.PHASES(PHASES)) i_gate (
    .phase   (phase),
    .scale   (scale),
    .advance (advance)
  );

  pix_shift_unit #(.BYTE_W(BYTE_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .byte_in (byte_data),
    .depth   (depth),
    .advance (advance),
    .pix     (pix),
    .active  (pix_active)
  );

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1) else $error("phase not one-hot");  // R1
  AST_READY_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |=> !byte_ready) else $error("ready held twice");  // R1

endmodule

// File: tb/test_pix_serializer.sv
module test_pix_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] phase = 8'h01;
  logic [1:0] scale = 2'd0;
  logic [1:0] depth = 2'd0;
  logic [7:0] byte_data = 8'h00;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [3:0] pix;
  logic       pix_active;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  int unsigned m_byte = 0;
  int unsigned m_bpp = 1;
  int unsigned m_idx = 0;
  bit          m_act = 1'b0;
  bit          m_load = 1'b0;
  string       sect = "";

  always #10 clk = ~clk;

  pix_serializer i_pix_serializer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .scale(scale), .depth(depth),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .pix(pix), .pix_active(pix_active)
  );

  function automatic int unsigned bpp_of(input logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit adv_of(input logic [1:0] s, input logic [7:0] ph);
    if (s == 2'd0) return 1'b1;
    if (s == 2'd1) return (ph & 8'h55) != 0;
    return (ph & 8'h11) != 0;
  endfunction

  function automatic int unsigned exp_pix();
    if (!m_act) return 0;
    return (m_byte >> (8 - m_bpp * (m_idx + 1))) & ((1 << m_bpp) - 1);
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    string t;
    if (sect != "") t = sect;
    else if (m_load) t = "R2";
    else if (!m_act) t = "R5";
    else t = "R4";
    check({t, " pix"}, pix, exp_pix());
    check({t, " active"}, pix_active, m_act);
    check("R1 ready", byte_ready, phase[0]);
  endtask

  // one clock: inputs already set; model steps, then compare after the edge
  task automatic step(input bit v, input logic [7:0] b, input logic [1:0] d, input logic [1:0] s);
    byte_valid = v; byte_data = b; depth = d; scale = s;
    m_load = v && phase[0];
    if (m_load) begin
      m_act = 1'b1; m_byte = b; m_bpp = bpp_of(d); m_idx = 0;
    end else if (m_act && adv_of(s, phase)) begin
      if (m_idx == 8 / m_bpp - 1) m_act = 1'b0;
      else m_idx++;
    end
    @(posedge clk);
    @(negedge clk);
    phase = {phase[6:0], phase[7]};
    check_outputs();
  endtask

  task automatic idle_to_phase0(input logic [1:0] d, input logic [1:0] s);
    while (!phase[0]) step(1'b0, 8'h00, d, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    sect = "R8";
    check("R8 reset pix", pix, 0);
    check("R8 reset active", pix_active, 0);
    rst_n = 1'b1;
    phase = 8'h01;

    // R3 R4: 1 bpp, x1, MSB first
    sect = "R3";
    step(1'b1, 8'hA5, 2'd0, 2'd0);
    for (int i = 0; i < 9; i++) step(1'b0, 8'h00, 2'd0, 2'd0);
    // 2 bpp x2, 4 bpp x4 and spare codes
    idle_to_phase0(2'd1, 2'd1);
    step(1'b1, 8'h1B, 2'd1, 2'd1);
    for (int i = 0; i < 9; i++) step(1'b0, 8'h00, 2'd1, 2'd1);
    sect = "R4";
    idle_to_phase0(2'd2, 2'd2);
    step(1'b1, 8'hC3, 2'd2, 2'd2);
    for (int i = 0; i < 9; i++) step(1'b0, 8'h00, 2'd2, 2'd2);
    idle_to_phase0(2'd3, 2'd3);
    step(1'b1, 8'h7E, 2'd3, 2'd3);
    for (int i = 0; i < 9; i++) step(1'b0, 8'h00, 2'd3, 2'd3);
    // R9: valid off phase 0
    sect = "R9";
    idle_to_phase0(2'd0, 2'd0);
    for (int i = 0; i < 16; i++) step(!phase[0], 8'hFF, 2'd0, 2'd0);
    // R6: restart over an active byte at x4
    sect = "R6";
    idle_to_phase0(2'd0, 2'd2);
    step(1'b1, 8'hF0, 2'd0, 2'd2);
    for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 2'd0, 2'd2);
    step(1'b1, 8'h0F, 2'd0, 2'd2);
    // R7: depth changes mid-byte
    sect = "R7";
    for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 2'(i % 4), 2'd2);
    // R8: reset mid-byte
    sect = "R8";
    idle_to_phase0(2'd0, 2'd1);
    step(1'b1, 8'hFF, 2'd0, 2'd1);
    step(1'b0, 8'h00, 2'd0, 2'd1);
    rst_n = 1'b0;
    #1;
    check("R8 async pix", pix, 0);
    check("R8 async active", pix_active, 0);
    m_act = 1'b0;
    @(negedge clk);
    phase = 8'h01;
    rst_n = 1'b1;

    // random mix
    sect = "";
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      s = (i % 64 == 0) ? 2'($urandom % 4) : scale;
      step(($urandom % 3) != 0, 8'($urandom), 2'($urandom % 4), s);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule